// File: doc/BRIEF.md
# Serial Drum Controller Command Decoder

This block sits between a processor's I/O instruction bus and the transfer engine of a serial drum controller. Each I/O instruction presents a device-select code, a 6-bit pulse field and the 18-bit accumulator for one cycle, qualified by `iot_valid`. The controller answers on three consecutive device codes. The first code loads the memory address and the transfer direction. The second code tests the completion flag, clears the flags, or loads a sector number and starts a transfer. The third code tests for the absence of an error, or clears the flags and restarts at the sector already held.

The block holds the 15-bit memory address, the direction bit, the 9-bit sector number (512 sectors), and the completion and error flags. It returns a skip answer to the processor in the same cycle as the instruction. The interrupt request line follows the completion flag. A one-cycle start strobe tells the transfer engine to begin. The engine reports back through `xfer_done` and `xfer_err`, which set the flags. All pins are plain control and status signals. An instruction is a single-cycle event with no back-pressure, so there is no valid/ready handshake.

Top module: `drum_iot_decoder`

## Requirements
- R1: With `iot_valid` high and `dev_sel` equal to DEV_ADDR (octal 60), a pulse field `p` with `(p & 'o27) == 'o06` loads `mem_addr` from `acc[14:0]` and `write_mode` from `p[5]` (0 = read, 1 = write). Both are visible after the next clock edge. Pulse bit 3 does not take part in this match.
- R2: With `dev_sel` equal to DEV_SECT (octal 61) and `p[0]` set, `skip` is high in the same cycle exactly when the completion flag is set.
- R3: On DEV_SECT, `p[1]` clears both the completion flag and the error flag at the next clock edge.
- R4: On DEV_SECT, `p[2]` loads `sector` from `acc[8:0]` and raises `start` for exactly the one cycle that follows the instruction. The new `sector` is visible in that same cycle.
- R5: With `dev_sel` equal to DEV_STAT (octal 62) and `p[0]` set, `skip` is high in the same cycle exactly when the error flag is clear.
- R6: On DEV_STAT, `p[2]` clears both flags and raises `start` for one cycle. `sector` keeps its value.
- R7: While `rst_n` is low, `mem_addr`, `write_mode`, `sector`, both flags and `start` are held at zero. A start that is due in the cycle after an instruction is cancelled when reset arrives at that edge.
- R8: `irq` equals the completion flag. It rises in the cycle after `xfer_done` is sampled high.
- R9: A high `xfer_done` or `xfer_err` sets its flag even when a clear arrives in the same cycle.
- R10: Nothing changes when `iot_valid` is low, when `dev_sel` matches none of the three codes, or when DEV_ADDR sees a pulse field that fails the R1 match. The bits of one instruction act together. A skip test reads the flags as they stood before that instruction's own clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iot_valid | input | 1 | An I/O instruction is present this cycle |
| dev_sel | input | 6 | Device-select code of the instruction |
| pulse | input | 6 | Pulse field of the instruction |
| acc | input | 18 | Accumulator value |
| xfer_done | input | 1 | Transfer engine finished; sets the completion flag |
| xfer_err | input | 1 | Transfer engine error; sets the error flag |
| skip | output | 1 | Skip answer to the processor (combinational) |
| irq | output | 1 | Interrupt request, equal to the completion flag |
| start | output | 1 | One-cycle start strobe to the transfer engine |
| mem_addr | output | 15 | Memory address register |
| write_mode | output | 1 | Direction: 0 read, 1 write |
| sector | output | 9 | Sector address register |

## Verification
`skip` is combinational. It is due in the cycle the instruction is presented and reflects the flags as they stood before that cycle's edge. Every register result lands one edge after the stimulus: `mem_addr`, `write_mode`, `sector`, `irq` and the one-cycle `start`. The bench drives inputs on the falling edge. It compares `skip` against its model a moment later, before the rising edge. After the rising edge it advances the model and compares every registered output at the next falling edge, before it drives anything new. This fixes each check to one cycle, and any output that is a cycle early or late is reported.

// File: rtl/drum_iot_pkg.sv
package drum_iot_pkg;
  // Decoded actions of one I/O instruction
  typedef struct packed {
    logic load_addr;   // load memory address and direction
    logic dir_write;   // captured direction bit
    logic test_done;   // skip if completion flag set
    logic test_noerr;  // skip if error flag clear
    logic clear_flags; // clear completion and error
    logic load_sect;   // load sector register
    logic kick;        // request a transfer start
  } iot_cmd_t;
endpackage

// File: rtl/drum_iot_decode.sv
module drum_iot_decode
  import drum_iot_pkg::*;
#(
  parameter int DEV_W    = 6,
  parameter int PULSE_W  = 6,
  parameter logic [DEV_W-1:0] DEV_ADDR = 6'o60,
  parameter logic [DEV_W-1:0] DEV_SECT = 6'o61,
  parameter logic [DEV_W-1:0] DEV_STAT = 6'o62
) (
  input  logic               iot_valid,
  input  logic [DEV_W-1:0]   dev_sel,
  input  logic [PULSE_W-1:0] pulse,
  output iot_cmd_t           cmd
);
  localparam logic [PULSE_W-1:0] LOAD_MASK  = PULSE_W'('o27);
  localparam logic [PULSE_W-1:0] LOAD_MATCH = PULSE_W'('o06);

  logic hit_addr, hit_sect, hit_stat;
  logic unused_pulse_bit;

  assign hit_addr = iot_valid && (dev_sel == DEV_ADDR);
  assign hit_sect = iot_valid && (dev_sel == DEV_SECT);
  assign hit_stat = iot_valid && (dev_sel == DEV_STAT);
  assign unused_pulse_bit = pulse[3];

  always_comb begin
    cmd             = '0;
    cmd.load_addr   = hit_addr && ((pulse & LOAD_MASK) == LOAD_MATCH);
    cmd.dir_write   = pulse[5];
    cmd.test_done   = hit_sect && pulse[0];
    cmd.test_noerr  = hit_stat && pulse[0];
    cmd.clear_flags = (hit_sect && pulse[1]) || (hit_stat && pulse[2]);
    cmd.load_sect   = hit_sect && pulse[2];
    cmd.kick        = (hit_sect || hit_stat) && pulse[2];
  end
endmodule

// File: rtl/drum_flag.sv
module drum_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q
);
  // Set wins over clear
  always_ff @(posedge clk) begin
    if (!rst_n)     q <= 1'b0;
    else if (set_i) q <= 1'b1;
    else if (clr_i) q <= 1'b0;
  end
endmodule

// File: rtl/drum_iot_decoder.sv
module drum_iot_decoder
  import drum_iot_pkg::*;
#(
  parameter int DEV_W   = 6,
  parameter int PULSE_W = 6,
  parameter int AC_W    = 18,
  parameter int ADDR_W  = 15,
  parameter int SECT_W  = 9,
  parameter logic [DEV_W-1:0] DEV_ADDR = 6'o60,
  parameter logic [DEV_W-1:0] DEV_SECT = 6'o61,
  parameter logic [DEV_W-1:0] DEV_STAT = 6'o62
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               iot_valid,
  input  logic [DEV_W-1:0]   dev_sel,
  input  logic [PULSE_W-1:0] pulse,
  input  logic [AC_W-1:0]    acc,
  input  logic               xfer_done,
  input  logic               xfer_err,
  output logic               skip,
  output logic               irq,
  output logic               start,
  output logic [ADDR_W-1:0]  mem_addr,
  output logic               write_mode,
  output logic [SECT_W-1:0]  sector
);
  localparam int NFLAG = 2;
  localparam int F_DONE = 0;
  localparam int F_ERR  = 1;

  iot_cmd_t         cmd;
  logic [NFLAG-1:0] flag_set, flag_q;
  logic             unused_acc;

  assign unused_acc = ^acc[AC_W-1:ADDR_W];

  drum_iot_decode #(
    .DEV_W(DEV_W), .PULSE_W(PULSE_W),
    .DEV_ADDR(DEV_ADDR), .DEV_SECT(DEV_SECT), .DEV_STAT(DEV_STAT)
  ) u_dec (
    .iot_valid(iot_valid), .dev_sel(dev_sel), .pulse(pulse), .cmd(cmd)
  );

  assign flag_set[F_DONE] = xfer_done;
  assign flag_set[F_ERR]  = xfer_err;

  for (genvar g = 0; g < NFLAG; g++) begin : g_flag
    drum_flag u_flag (
      .clk(clk), .rst_n(rst_n),
      .set_i(flag_set[g]), .clr_i(cmd.clear_flags), .q(flag_q[g])
    );
  end

  // Skip reads the flags before this instruction's own clear
  assign skip = (cmd.test_done  &&  flag_q[F_DONE]) ||
                (cmd.test_noerr && !flag_q[F_ERR]);
  assign irq  = flag_q[F_DONE];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_addr   <= '0;
      write_mode <= 1'b0;
      sector     <= '0;
      start      <= 1'b0;
    end else begin
      start <= cmd.kick;
      if (cmd.load_addr) begin
        mem_addr   <= acc[ADDR_W-1:0];
        write_mode <= cmd.dir_write;
      end
      if (cmd.load_sect) sector <= acc[SECT_W-1:0];
    end
  end
endmodule

// File: rtl/drum_iot_checker.sv
module drum_iot_checker #(
  parameter int DEV_W   = 6,
  parameter int PULSE_W = 6,
  parameter int AC_W    = 18,
  parameter int ADDR_W  = 15,
  parameter int SECT_W  = 9
) (
  input logic               clk,
  input logic               rst_n,
  input logic               iot_valid,
  input logic [DEV_W-1:0]   dev_sel,
  input logic [PULSE_W-1:0] pulse,
  input logic [AC_W-1:0]    acc,
  input logic               xfer_done,
  input logic               skip,
  input logic               irq,
  input logic               start,
  input logic [ADDR_W-1:0]  mem_addr,
  input logic [SECT_W-1:0]  sector
);
  // R1
  addr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (iot_valid && dev_sel == 6'o60 && (pulse & 6'o27) == 6'o06)
      |=> mem_addr == $past(acc[ADDR_W-1:0]));
  // R4
  start_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> $past(iot_valid && (dev_sel == 6'o61 || dev_sel == 6'o62) && pulse[2]));
  // R3
  clear_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (iot_valid && dev_sel == 6'o61 && pulse[1] && !xfer_done) |=> !irq);
  // R9
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |=> irq);
  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !iot_valid |=> ($stable(mem_addr) && $stable(sector) && !start));
  // R2
  skip_needs_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    skip |-> iot_valid);
endmodule

bind drum_iot_decoder drum_iot_checker #(
  .DEV_W(DEV_W), .PULSE_W(PULSE_W), .AC_W(AC_W), .ADDR_W(ADDR_W), .SECT_W(SECT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .iot_valid(iot_valid), .dev_sel(dev_sel),
  .pulse(pulse), .acc(acc), .xfer_done(xfer_done), .skip(skip), .irq(irq),
  .start(start), .mem_addr(mem_addr), .sector(sector)
);

// File: tb/test_drum_iot_decoder.sv
`timescale 1ns/1ps
module test_drum_iot_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        iot_valid = 1'b0;
  logic [5:0]  dev_sel = '0;
  logic [5:0]  pulse = '0;
  logic [17:0] acc = '0;
  logic        xfer_done = 1'b0, xfer_err = 1'b0;
  logic        skip, irq, start, write_mode;
  logic [14:0] mem_addr;
  logic [8:0]  sector;

  int checks = 0, errors = 0;
  bit finished = 0;

  // Reference model state
  int m_ma = 0, m_sect = 0;
  bit m_wr = 0, m_done = 0, m_err = 0, m_start = 0;

  always #2.5 clk = ~clk;

  drum_iot_decoder i_drum_iot_decoder (
    .clk(clk), .rst_n(rst_n), .iot_valid(iot_valid), .dev_sel(dev_sel),
    .pulse(pulse), .acc(acc), .xfer_done(xfer_done), .xfer_err(xfer_err),
    .skip(skip), .irq(irq), .start(start), .mem_addr(mem_addr),
    .write_mode(write_mode), .sector(sector)
  );

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic check_regs(string tag);
    chk(tag, "irq", int'(irq), int'(m_done));
    chk(tag, "start", int'(start), int'(m_start));
    chk(tag, "mem_addr", int'(mem_addr), m_ma);
    chk(tag, "write_mode", int'(write_mode), int'(m_wr));
    chk(tag, "sector", int'(sector), m_sect);
  endtask

  // One cycle: drive at negedge, check skip, advance model on posedge, check regs
  task automatic step(string tag, bit v, logic [5:0] d, logic [5:0] p,
                      logic [17:0] a, bit dn, bit er);
    bit exp_skip, clr;
    iot_valid = v; dev_sel = d; pulse = p; acc = a; xfer_done = dn; xfer_err = er;
    #1;
    exp_skip = v && ((d == 6'o61 && p[0] && m_done) || (d == 6'o62 && p[0] && !m_err));
    chk(tag, "skip", int'(skip), int'(exp_skip));
    @(posedge clk);
    clr = v && ((d == 6'o61 && p[1]) || (d == 6'o62 && p[2]));
    if (dn) m_done = 1; else if (clr) m_done = 0;
    if (er) m_err = 1;  else if (clr) m_err = 0;
    m_start = v && (d == 6'o61 || d == 6'o62) && p[2];
    if (v && d == 6'o60 && (p & 6'o27) == 6'o06) begin
      m_ma = int'(a[14:0]); m_wr = p[5];
    end
    if (v && d == 6'o61 && p[2]) m_sect = int'(a[8:0]);
    @(negedge clk);
    check_regs(tag);
  endtask

  task automatic idle(string tag);
    step(tag, 0, 6'o00, 6'o00, 18'o0, 0, 0);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    iot_valid = 0; xfer_done = 0; xfer_err = 0;
    @(posedge clk);
    m_ma = 0; m_sect = 0; m_wr = 0; m_done = 0; m_err = 0; m_start = 0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #500000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    do_reset();
    check_regs("R7");                               // reset state
    idle("R10");
    // R1: read load, write load, bit 3 ignored, non-matching pulse
    step("R1", 1, 6'o60, 6'o06, 18'o123456, 0, 0);
    step("R1", 1, 6'o60, 6'o46, 18'o054321, 0, 0);
    step("R1", 1, 6'o60, 6'o16, 18'o007777, 0, 0);
    step("R10", 1, 6'o60, 6'o26, 18'o011111, 0, 0);
    step("R10", 1, 6'o60, 6'o07, 18'o022222, 0, 0);
    // R4: load sector with upper bits set, start for one cycle only
    step("R4", 1, 6'o61, 6'o04, 18'o001777, 0, 0);
    idle("R4");
    // R2 / R8: done raised, skip on done
    step("R2", 1, 6'o61, 6'o01, 18'o0, 0, 0);
    step("R8", 0, 6'o00, 6'o00, 18'o0, 1, 0);
    step("R2", 1, 6'o61, 6'o01, 18'o0, 0, 0);
    // R5: error clear then set
    step("R5", 1, 6'o62, 6'o01, 18'o0, 0, 0);
    step("R5", 0, 6'o00, 6'o00, 18'o0, 0, 1);
    step("R5", 1, 6'o62, 6'o01, 18'o0, 0, 0);
    // R10: clear ignored without valid or on a foreign code
    step("R10", 0, 6'o61, 6'o02, 18'o0, 0, 0);
    step("R10", 1, 6'o63, 6'o07, 18'o000123, 0, 0);
    // R3: clear both flags
    step("R3", 1, 6'o61, 6'o02, 18'o0, 0, 0);
    step("R3", 1, 6'o62, 6'o01, 18'o0, 0, 0);
    // R9: set wins over clear in the same cycle
    step("R9", 1, 6'o61, 6'o02, 18'o0, 1, 1);
    step("R9", 1, 6'o62, 6'o01, 18'o0, 0, 0);
    // R6: restart clears flags, keeps sector
    step("R6", 1, 6'o62, 6'o04, 18'o000042, 0, 0);
    step("R6", 1, 6'o61, 6'o01, 18'o0, 0, 0);
    // R10: combined skip+clear+start reads flags before its clear
    step("R10", 0, 6'o00, 6'o00, 18'o0, 1, 0);
    step("R10", 1, 6'o61, 6'o07, 18'o000400, 0, 0);
    step("R6", 1, 6'o62, 6'o05, 18'o0, 0, 1);
    step("R5", 1, 6'o62, 6'o01, 18'o0, 0, 0);
    // R7: reset cancels a start due next cycle
    iot_valid = 1; dev_sel = 6'o61; pulse = 6'o04; acc = 18'o000077;
    rst_n = 1'b0;
    @(posedge clk);
    m_ma = 0; m_sect = 0; m_wr = 0; m_done = 0; m_err = 0; m_start = 0;
    @(negedge clk);
    check_regs("R7");
    iot_valid = 0;
    rst_n = 1'b1;
    idle("R7");
    step("R1", 1, 6'o60, 6'o46, 18'o777777, 0, 0);
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule